// File: doc/BRIEF.md
# Weighted-Code Decade Counter

This block is one divide-by-ten counting stage. Four single-bit stages, named A, B, D and C, hold the count. Each stage carries a decimal weight, and a stage adds its weight only while its true side is set. The weights are 1 for A, 2 for B, 2 for C and 4 for D, which gives a 4-2-2-1 code in place of plain 8-4-2-1 binary. Each count event moves the count up by one. Only ten of the sixteen stage patterns are legal, so the stage divides its input by ten.

The stages are presented as a 4-bit word with D in bit 3, C in bit 2, B in bit 1 and A in bit 0. The block also gives the decoded decimal digit (the weighted sum) for a display driver. It gives a one-cycle carry pulse that can feed the count-enable of the next decade. Steering logic picks which stages flip on each event. B's state steers D and C, and D's state steers only C. The steering also pulls any of the six unused patterns back into the legal set on the next event. A synchronous preset port writes all four stages at once. Its role is to place the stage in a chosen pattern, including the unused ones.

Top module: `dec_decade`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `code` is 0000, `digit` is 0 and `carry` is 0.
- R2: Starting from a legal code, each cycle with `cnt_en` high and `ld_en` low moves the count to the next code in this ring, written as D C B A: 0000, 0001, 0010, 0011, 1000, 1001, 1010, 1101, 1110, 1111, then back to 0000. These codes stand for the digits 0 to 9 in that order.
- R3: `digit` always equals 4·D + 2·C + 2·B + 1·A, where D, C, B and A are `code` bits 3, 2, 1 and 0, so the value seven reads as 1101.
- R4: A cycle with both `cnt_en` and `ld_en` low leaves `code` and `digit` unchanged.
- R5: `carry` is high for exactly the one cycle that follows a count event taken from digit 9. It is low in every other cycle.
- R6: A cycle with `ld_en` high loads `ld_code` into the stages on the next edge, whatever the level of `cnt_en`, and it raises no carry.
- R7: From any of the six unused codes (0100, 0101, 0110, 0111, 1011, 1100), one count event sets the code that stands for (weighted sum + 1) mod 10. This maps 0100→0011, 0101→1000, 0110→1001, 0111→1010, 1011→1110 and 1100→1101.
- R8: Over a long run of count events, with idle cycles between some of them, `digit` follows a plain modulo-10 count of the events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low; clears all stages |
| cnt_en | input | 1 | Count event, one per cycle while high |
| ld_en | input | 1 | Preset strobe; takes priority over a count |
| ld_code | input | 4 | Preset pattern, DCBA order |
| code | output | 4 | Stage states, D in bit 3 down to A in bit 0 |
| digit | output | 4 | Weighted sum of the stages, 0 to 9 on legal codes |
| carry | output | 1 | One-cycle pulse after a count taken from 9 |

## Verification
Counting alone never reaches the six unused patterns, because legal codes only ever step to other legal codes. The recovery rule is therefore the hardest behaviour to bring about. The bench uses the preset port to write each unused pattern in turn. It then applies one count event and checks the code that results. It also confirms that a preset held together with a count wins, and that a count taken from 9 gives exactly one carry cycle.

// File: rtl/dec_decade_pkg.sv
package dec_decade_pkg;
    localparam int NSTG = 4;
    localparam int DW   = 4;
    localparam int MODULUS = 10;

    typedef logic [NSTG-1:0] code_t;
    typedef logic [DW-1:0]   digit_t;

    // bit 0 = A, bit 1 = B, bit 2 = C, bit 3 = D
    localparam digit_t WEIGHT [NSTG] = '{4'd1, 4'd2, 4'd2, 4'd4};

    function automatic digit_t weigh(code_t c);
        digit_t s;
        s = '0;
        for (int i = 0; i < NSTG; i++) begin
            if (c[i]) s = s + WEIGHT[i];
        end
        return s;
    endfunction

    function automatic code_t encode(digit_t v);
        case (v)
            4'd0:    return 4'b0000;
            4'd1:    return 4'b0001;
            4'd2:    return 4'b0010;
            4'd3:    return 4'b0011;
            4'd4:    return 4'b1000;
            4'd5:    return 4'b1001;
            4'd6:    return 4'b1010;
            4'd7:    return 4'b1101;
            4'd8:    return 4'b1110;
            4'd9:    return 4'b1111;
            default: return 4'b0000;
        endcase
    endfunction

    function automatic logic is_legal(code_t c);
        return encode(weigh(c)) == c;
    endfunction

    typedef struct packed {
        logic carry;
    } top_state_t;
endpackage

// File: rtl/dec_stage.sv
module dec_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    input  logic tog,
    input  logic ld,
    input  logic ld_val,
    output logic q
);
    logic q_d, q_q;

    always_comb begin
        q_d = q_q;
        if (ld)
            q_d = ld_val;
        else if (adv && tog)
            q_d = ~q_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= 1'b0;
        else        q_q <= q_d;
    end

    assign q = q_q;
endmodule

// File: rtl/dec_steer.sv
module dec_steer
    import dec_decade_pkg::*;
(
    input  code_t cur,
    output code_t tog,
    output logic  wrap
);
    digit_t sum, nxt_val;
    code_t  nxt;

    always_comb begin
        sum     = weigh(cur);
        wrap    = (sum == digit_t'(MODULUS - 1));
        nxt_val = wrap ? '0 : sum + 4'd1;
        nxt     = encode(nxt_val);
        tog     = cur ^ nxt;
    end
endmodule

// File: rtl/dec_weigh.sv
module dec_weigh
    import dec_decade_pkg::*;
(
    input  code_t  cur,
    output digit_t val
);
    always_comb val = weigh(cur);
endmodule

// File: rtl/dec_decade.sv
module dec_decade
    import dec_decade_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cnt_en,
    input  logic       ld_en,
    input  logic [3:0] ld_code,
    output logic [3:0] code,
    output logic [3:0] digit,
    output logic       carry
);
    code_t      stg_q;
    code_t      tog;
    logic       wrap;
    logic       adv;
    top_state_t st_d, st_q;

    assign adv = cnt_en && !ld_en;

    dec_steer i_steer (.cur(stg_q), .tog(tog), .wrap(wrap));

    for (genvar g = 0; g < NSTG; g++) begin : g_stage
        dec_stage i_stage (
            .clk   (clk),
            .rst_n (rst_n),
            .adv   (adv),
            .tog   (tog[g]),
            .ld    (ld_en),
            .ld_val(ld_code[g]),
            .q     (stg_q[g])
        );
    end

    dec_weigh i_weigh (.cur(stg_q), .val(digit));

    always_comb begin
        st_d.carry = adv && wrap;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign code  = stg_q;
    assign carry = st_q.carry;
endmodule

// File: rtl/dec_decade_chk.sv
module dec_decade_chk
    import dec_decade_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       cnt_en,
    input logic       ld_en,
    input logic [3:0] ld_code,
    input logic [3:0] code,
    input logic [3:0] digit,
    input logic       carry
);
    a_r6_load: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en |=> (code == $past(ld_code)) && !carry);

    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_en && !cnt_en) |=> $stable(code));

    a_r5_carry_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && !ld_en && digit == 4'd9) |=> carry);

    a_r5_carry_zero: assert property (@(posedge clk) disable iff (!rst_n)
        carry |-> (code == 4'b0000));

    a_r7_legal_after_count: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && !ld_en) |=> is_legal(code));

    a_r2_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && !ld_en && is_legal(code)) |=>
            (digit == (($past(digit) == 4'd9) ? 4'd0 : $past(digit) + 4'd1)));

    a_r3_digit_range: assert property (@(posedge clk) disable iff (!rst_n)
        digit <= 4'd9);
endmodule

bind dec_decade dec_decade_chk i_chk (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .ld_en(ld_en),
    .ld_code(ld_code), .code(code), .digit(digit), .carry(carry)
);

// File: tb/test_dec_decade.sv
module test_dec_decade;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cnt_en = 1'b0;
    logic       ld_en = 1'b0;
    logic [3:0] ld_code = 4'b0000;
    logic [3:0] code;
    logic [3:0] digit;
    logic       carry;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dec_decade i_dec_decade (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .ld_en(ld_en),
        .ld_code(ld_code), .code(code), .digit(digit), .carry(carry)
    );

    function automatic logic [3:0] exp_code(int v);
        case (v)
            0: return 4'b0000; 1: return 4'b0001; 2: return 4'b0010;
            3: return 4'b0011; 4: return 4'b1000; 5: return 4'b1001;
            6: return 4'b1010; 7: return 4'b1101; 8: return 4'b1110;
            default: return 4'b1111;
        endcase
    endfunction

    function automatic int exp_sum(logic [3:0] c);
        return 4*c[3] + 2*c[2] + 2*c[1] + c[0];
    endfunction

    task automatic check(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // called at a falling edge; leaves at the next falling edge
    task automatic cycle(logic en, logic ld, logic [3:0] val);
        cnt_en = en; ld_en = ld; ld_code = val;
        @(negedge clk);
        cnt_en = 1'b0; ld_en = 1'b0;
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R1", "code in reset", code, 0);
        check("R1", "digit in reset", digit, 0);
        check("R1", "carry in reset", carry, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "code after release", code, 0);
        check("R1", "carry after release", carry, 0);
    endtask

    task automatic t_sequence;
        for (int i = 1; i <= 10; i++) begin
            cycle(1'b1, 1'b0, 4'b0000);
            check("R2", "ring code", code, exp_code(i % 10));
            check("R3", "weighted digit", digit, exp_sum(code));
        end
        cycle(1'b0, 1'b1, 4'b1101);
        check("R3", "seven reads 1101 as digit", digit, 7);
    endtask

    task automatic t_hold;
        cycle(1'b0, 1'b1, 4'b1010);
        for (int i = 0; i < 3; i++) begin
            cycle(1'b0, 1'b0, 4'b0101);
            check("R4", "held code", code, 4'b1010);
            check("R4", "held digit", digit, 6);
        end
    endtask

    task automatic t_carry;
        cycle(1'b0, 1'b1, 4'b1110);
        cycle(1'b1, 1'b0, 4'b0000);
        check("R5", "no carry 8->9", carry, 0);
        cycle(1'b1, 1'b0, 4'b0000);
        check("R5", "carry on 9->0", carry, 1);
        check("R5", "code after wrap", code, 0);
        cycle(1'b0, 1'b0, 4'b0000);
        check("R5", "carry one cycle", carry, 0);
    endtask

    task automatic t_load;
        cycle(1'b0, 1'b1, 4'b1111);
        cycle(1'b1, 1'b1, 4'b0011);
        check("R6", "load beats count", code, 4'b0011);
        check("R6", "no carry on load from 9", carry, 0);
    endtask

    task automatic t_illegal;
        logic [3:0] bad [6] = '{4'b0100, 4'b0101, 4'b0110, 4'b0111, 4'b1011, 4'b1100};
        for (int i = 0; i < 6; i++) begin
            cycle(1'b0, 1'b1, bad[i]);
            check("R7", "illegal preset", code, bad[i]);
            cycle(1'b1, 1'b0, 4'b0000);
            check("R7", "recovered code", code, exp_code((exp_sum(bad[i]) + 1) % 10));
        end
    endtask

    task automatic t_reference;
        int refv;
        cycle(1'b0, 1'b1, 4'b0000);
        refv = 0;
        for (int i = 0; i < 130; i++) begin
            logic ev;
            logic wexp;
            ev = (i % 7 != 3);
            wexp = ev && (refv == 9);
            cycle(ev, 1'b0, 4'b0000);
            if (ev) refv = (refv + 1) % 10;
            check("R8", "digit vs reference", digit, refv);
            check("R8", "code vs reference", code, exp_code(refv));
            check("R5", "carry vs reference", carry, wexp);
        end
    endtask

    initial begin
        t_reset();
        t_sequence();
        t_hold();
        t_carry();
        t_load();
        t_illegal();
        t_reference();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_chk++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule